// File: doc/BRIEF.md
# Message-Signalled Interrupt Aggregator

The block gathers eleven level-sensitive interrupt lines (six PCI slot lines, an external host-bus line, a default line, two spare positions and a serial-port line) and reports them to a processor through a posted write, not a wire. Each line is synchronised, and the block keeps three views of it: the live level, a pending capture of every rising edge, and a request register that only enabled, implemented lines can set. When the request register goes from empty to non-empty, one write message goes out on a valid/ready master port. It carries a programmed target address and a small data word that identifies this controller.

Software programs the target word and the enable mask through a small register port. On a message it reads the request register, which returns the requesting lines and clears them. It then reads the live-level register to find lines that are still held high, and so treats them as level-triggered. Edges that arrive before that read merge into the same request word and queue no further message. A line that is already high when it is enabled produces nothing by itself.

Top module: `msg_irq_agg`

## Requirements
- R1: After reset, the enable mask, request, pending and target registers read zero and `msg_valid` is low.
- R2: The live-level register (offset 0x028, bit i = line i) shows each line's state two clock edges after the line changes, whatever the mask holds. A falling edge produces no request and no message.
- R3: A rising edge on line i with mask bit i set (mask at offset 0x018, bit i = 1 enables line i) sets request bit i. When the request register was empty, `msg_valid` rises on the third clock edge after the line changes.
- R4: A rising edge on a line whose mask bit is clear sets no request bit and sends no message. Setting the mask bit while the line is already high also sends no message.
- R5: Reading the request register (offset 0x00C) returns the set request bits and clears them. Only the lines in mask 0x5FF can be requested, so an edge on line 9 never sets a request bit or sends a message.
- R6: While the request register is non-empty, further edges on enabled lines merge into it and send no further message. After a read has cleared it, the next enabled edge sends a new message.
- R7: The pending register (offset 0x01C) captures rising edges on all eleven lines, whatever the mask holds. Reading it returns and clears it, and leaves the request and live-level registers unchanged.
- R8: A message carries `msg_addr` = target word with its low five bits cleared and `msg_data` = the low five bits of the target word. `msg_valid`, `msg_addr` and `msg_data` hold steady until `msg_ready` is seen high.
- R9: While the target word (offset 0x004) is zero, no message is sent. The request bits are still recorded.
- R10: The target and mask registers read back what was written, with the mask limited to 11 bits. Writes to the request, pending and level offsets have no effect. Read data is valid one cycle after the access, with `reg_rvalid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_lines | input | 11 | Asynchronous level-sensitive interrupt lines |
| reg_sel | input | 1 | Register access strobe, one cycle per access |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| reg_rvalid | output | 1 | Read data valid, one cycle after a read strobe |
| msg_valid | output | 1 | Outgoing write message valid |
| msg_ready | input | 1 | Outgoing write message accepted |
| msg_addr | output | 32 | Outgoing write address |
| msg_data | output | 32 | Outgoing write data |

## Verification
Errors in the edge detector or the request word first show at the message port. A lost request keeps `msg_valid` low on the third edge after a line rises. A request word that fails to clear suppresses the next message after a request read. A wrong view of the mask or of the implemented-bit set gives a wrong value on the first read of the request or pending register after the stimulus, one cycle after the access. A message register that does not hold shows as a changed address or data word in the cycle after `msg_valid` with `msg_ready` low.

// File: rtl/mia_pkg.sv
// Shared constants and register decode for the message interrupt aggregator.
// Assumes a 12-bit byte offset register port; offsets are fixed by software.
package mia_pkg;
    localparam int unsigned OFS_W = 12;

    localparam logic [OFS_W-1:0] OFS_TARGET = 12'h004;
    localparam logic [OFS_W-1:0] OFS_REQ    = 12'h00C;
    localparam logic [OFS_W-1:0] OFS_MASK   = 12'h018;
    localparam logic [OFS_W-1:0] OFS_PEND   = 12'h01C;
    localparam logic [OFS_W-1:0] OFS_LEVEL  = 12'h028;

    typedef enum logic [2:0] {
        RS_NONE,
        RS_TARGET,
        RS_REQ,
        RS_MASK,
        RS_PEND,
        RS_LEVEL
    } reg_slot_e;

    // Map a byte offset onto a register slot.
    function automatic reg_slot_e slot_of(input logic [OFS_W-1:0] ofs);
        reg_slot_e s;
        case (ofs)
            OFS_TARGET: s = RS_TARGET;
            OFS_REQ:    s = RS_REQ;
            OFS_MASK:   s = RS_MASK;
            OFS_PEND:   s = RS_PEND;
            OFS_LEVEL:  s = RS_LEVEL;
            default:    s = RS_NONE;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/mia_line_sync.sv
// Two-flop synchroniser plus rising-edge detector for every interrupt line.
// Assumes lines are asynchronous levels; outputs are in the clk domain.
module mia_line_sync #(
    parameter int unsigned N_LINES = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] lines_in,
    output logic [N_LINES-1:0] level_o,
    output logic [N_LINES-1:0] rise_o
);
    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        logic meta_q;
        logic sync_q;
        logic prev_q;

        // Synchronise line i and remember its previous synchronised value.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                meta_q <= lines_in[i];
                sync_q <= meta_q;
                prev_q <= sync_q;
            end
        end

        assign level_o[i] = sync_q;
        assign rise_o[i]  = sync_q & ~prev_q;
    end
endmodule

// File: rtl/mia_irq_state.sv
// Request and pending state for the interrupt lines.
// Request: enabled, implemented rising edges, cleared by a request read.
// Pending: all rising edges, cleared by a pending read.
// trig_o pulses when the request word becomes non-empty (or refills in the
// same cycle as a clearing read), which is when one message is due.
module mia_irq_state #(
    parameter int unsigned        N_LINES   = 11,
    parameter logic [N_LINES-1:0] IMPL_MASK = 11'h5FF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] rise_i,
    input  logic [N_LINES-1:0] enable_i,
    input  logic               clr_req_i,
    input  logic               clr_pend_i,
    output logic [N_LINES-1:0] req_o,
    output logic [N_LINES-1:0] pend_o,
    output logic               trig_o
);
    logic [N_LINES-1:0] req_q;
    logic [N_LINES-1:0] pend_q;
    logic [N_LINES-1:0] req_set;
    logic [N_LINES-1:0] req_next;
    logic [N_LINES-1:0] pend_next;

    // Next-state of request and pending words, and message trigger.
    always_comb begin
        req_set   = rise_i & enable_i & IMPL_MASK;
        req_next  = (clr_req_i ? '0 : req_q) | req_set;
        pend_next = (clr_pend_i ? '0 : pend_q) | rise_i;
        trig_o    = (|req_set) && ((req_q == '0) || clr_req_i);
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q  <= '0;
            pend_q <= '0;
        end else begin
            req_q  <= req_next;
            pend_q <= pend_next;
        end
    end

    assign req_o  = req_q;
    assign pend_o = pend_q;
endmodule

// File: rtl/mia_msg_issue.sv
// Builds and holds the outgoing write message on a valid/ready port.
// Address is the target word with its identity field cleared; data is that
// identity field. A trigger while a message waits merges into it.
// A zero target word suppresses the message.
module mia_msg_issue #(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ID_BITS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_i,
    input  logic [DATA_W-1:0] target_i,
    input  logic              msg_ready,
    output logic              msg_valid,
    output logic [DATA_W-1:0] msg_addr,
    output logic [DATA_W-1:0] msg_data
);
    localparam logic [DATA_W-1:0] ID_FIELD = DATA_W'((64'd1 << ID_BITS) - 64'd1);

    logic valid_q;
    logic [DATA_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic free;
    logic launch;

    // A new message may load when the port is idle or being drained.
    always_comb begin
        free   = !valid_q || msg_ready;
        launch = trig_i && (target_i != '0) && free;
    end

    // Message holding register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
        end else if (launch) begin
            valid_q <= 1'b1;
            addr_q  <= target_i & ~ID_FIELD;
            data_q  <= target_i & ID_FIELD;
        end else if (valid_q && msg_ready) begin
            valid_q <= 1'b0;
        end
    end

    assign msg_valid = valid_q;
    assign msg_addr  = addr_q;
    assign msg_data  = data_q;
endmodule

// File: rtl/mia_regs.sv
// Register port: target and mask storage, read mux, read side effects.
// Assumes one-cycle access strobes; read data is registered.
module mia_regs #(
    parameter int unsigned N_LINES = 11,
    parameter int unsigned DATA_W  = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_sel,
    input  logic                     reg_wr,
    input  logic [mia_pkg::OFS_W-1:0] reg_addr,
    input  logic [DATA_W-1:0]        reg_wdata,
    input  logic [N_LINES-1:0]       level_i,
    input  logic [N_LINES-1:0]       req_i,
    input  logic [N_LINES-1:0]       pend_i,
    output logic [DATA_W-1:0]        target_o,
    output logic [N_LINES-1:0]       enable_o,
    output logic                     clr_req_o,
    output logic                     clr_pend_o,
    output logic [DATA_W-1:0]        reg_rdata,
    output logic                     reg_rvalid
);
    import mia_pkg::*;

    reg_slot_e          slot;
    logic               rd;
    logic               wr;
    logic [DATA_W-1:0]  rd_mux;
    logic [DATA_W-1:0]  target_q;
    logic [N_LINES-1:0] enable_q;
    logic [DATA_W-1:0]  rdata_q;
    logic               rvalid_q;

    // Decode the access and select read data.
    always_comb begin
        slot       = slot_of(reg_addr);
        rd         = reg_sel && !reg_wr;
        wr         = reg_sel && reg_wr;
        clr_req_o  = rd && (slot == RS_REQ);
        clr_pend_o = rd && (slot == RS_PEND);
        case (slot)
            RS_TARGET: rd_mux = target_q;
            RS_REQ:    rd_mux = DATA_W'(req_i);
            RS_MASK:   rd_mux = DATA_W'(enable_q);
            RS_PEND:   rd_mux = DATA_W'(pend_i);
            RS_LEVEL:  rd_mux = DATA_W'(level_i);
            default:   rd_mux = '0;
        endcase
    end

    // Writable configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            target_q <= '0;
            enable_q <= '0;
        end else if (wr) begin
            if (slot == RS_TARGET) target_q <= reg_wdata;
            if (slot == RS_MASK)   enable_q <= reg_wdata[N_LINES-1:0];
        end
    end

    // Registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= rd;
            if (rd) rdata_q <= rd_mux;
        end
    end

    assign target_o   = target_q;
    assign enable_o   = enable_q;
    assign reg_rdata  = rdata_q;
    assign reg_rvalid = rvalid_q;
endmodule

// File: rtl/msg_irq_agg.sv
// Message-signalled interrupt aggregator top level.
// Connects line synchroniser, request/pending state, message issue and
// register port. Assumes a single clock and synchronous active-low reset.
module msg_irq_agg #(
    parameter int unsigned        N_LINES   = 11,
    parameter int unsigned        DATA_W    = 32,
    parameter int unsigned        ID_BITS   = 5,
    parameter logic [N_LINES-1:0] IMPL_MASK = 11'h5FF
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_LINES-1:0]        irq_lines,
    input  logic                      reg_sel,
    input  logic                      reg_wr,
    input  logic [mia_pkg::OFS_W-1:0] reg_addr,
    input  logic [DATA_W-1:0]         reg_wdata,
    output logic [DATA_W-1:0]         reg_rdata,
    output logic                      reg_rvalid,
    output logic                      msg_valid,
    input  logic                      msg_ready,
    output logic [DATA_W-1:0]         msg_addr,
    output logic [DATA_W-1:0]         msg_data
);
    logic [N_LINES-1:0] level;
    logic [N_LINES-1:0] rise;
    logic [N_LINES-1:0] req_q;
    logic [N_LINES-1:0] pend_q;
    logic [N_LINES-1:0] enable;
    logic [DATA_W-1:0]  target;
    logic               clr_req;
    logic               clr_pend;
    logic               trig;

    mia_line_sync #(.N_LINES(N_LINES)) u_sync (
        .clk(clk), .rst_n(rst_n), .lines_in(irq_lines),
        .level_o(level), .rise_o(rise)
    );

    mia_irq_state #(.N_LINES(N_LINES), .IMPL_MASK(IMPL_MASK)) u_state (
        .clk(clk), .rst_n(rst_n), .rise_i(rise), .enable_i(enable),
        .clr_req_i(clr_req), .clr_pend_i(clr_pend),
        .req_o(req_q), .pend_o(pend_q), .trig_o(trig)
    );

    mia_msg_issue #(.DATA_W(DATA_W), .ID_BITS(ID_BITS)) u_msg (
        .clk(clk), .rst_n(rst_n), .trig_i(trig), .target_i(target),
        .msg_ready(msg_ready), .msg_valid(msg_valid),
        .msg_addr(msg_addr), .msg_data(msg_data)
    );

    mia_regs #(.N_LINES(N_LINES), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .level_i(level), .req_i(req_q), .pend_i(pend_q),
        .target_o(target), .enable_o(enable),
        .clr_req_o(clr_req), .clr_pend_o(clr_pend),
        .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid)
    );
endmodule

// File: rtl/msg_irq_agg_chk.sv
// Protocol and state checker for msg_irq_agg, attached by bind.
module msg_irq_agg_chk #(
    parameter int unsigned N_LINES = 11,
    parameter int unsigned DATA_W  = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_sel,
    input logic               reg_wr,
    input logic               reg_rvalid,
    input logic               msg_valid,
    input logic               msg_ready,
    input logic [DATA_W-1:0]  msg_addr,
    input logic [DATA_W-1:0]  msg_data,
    input logic [N_LINES-1:0] req_q
);
    assert_msg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

    assert_msg_target_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> ((msg_addr | msg_data) != '0));

    assert_msg_needs_request_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) |-> (req_q != '0));

    assert_no_line9_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !req_q[9]);

    assert_read_response_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && !reg_wr) |=> reg_rvalid);

    assert_no_spurious_response_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_sel && !reg_wr) |=> !reg_rvalid);
endmodule

bind msg_irq_agg msg_irq_agg_chk #(.N_LINES(N_LINES), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_rvalid(reg_rvalid), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data), .req_q(req_q)
);

// File: tb/msg_irq_agg_bench.sv
// Directed bench for msg_irq_agg: one task per scenario.
module msg_irq_agg_bench;
    localparam logic [11:0] A_TGT = 12'h004;
    localparam logic [11:0] A_REQ = 12'h00C;
    localparam logic [11:0] A_MSK = 12'h018;
    localparam logic [11:0] A_PND = 12'h01C;
    localparam logic [11:0] A_LVL = 12'h028;
    localparam logic [31:0] TGT   = 32'hABCD_0003;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] irq_lines = '0;
    logic        reg_sel = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_rvalid;
    logic        msg_valid;
    logic        msg_ready = 1'b0;
    logic [31:0] msg_addr;
    logic [31:0] msg_data;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10ns clk = ~clk;

    msg_irq_agg u_msg_irq_agg (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
        .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_addr(msg_addr), .msg_data(msg_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        cyc(1);
        reg_sel = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a;
        cyc(1);
        reg_sel = 1'b0;
        d = reg_rdata;
        n_checks++;
        if (reg_rvalid !== 1'b1) begin
            n_fail++;
            $display("FAIL R10 rvalid: actual %b expected 1", reg_rvalid);
        end
    endtask

    task automatic drain();
        msg_ready = 1'b1;
        cyc(1);
        msg_ready = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 msg_valid", 32'(msg_valid), 0);
        rd(A_MSK, v); chk("R1 mask", v, 0);
        rd(A_REQ, v); chk("R1 request", v, 0);
        rd(A_PND, v); chk("R1 pending", v, 0);
        rd(A_TGT, v); chk("R1 target", v, 0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(A_TGT, TGT);          rd(A_TGT, v); chk("R10 target readback", v, TGT);
        wr(A_MSK, 32'hFFFF_FFFF); rd(A_MSK, v); chk("R10 mask width", v, 32'h7FF);
        wr(A_LVL, 32'hFFFF_FFFF); rd(A_LVL, v); chk("R10 level write ignored", v, 0);
        wr(A_REQ, 32'hFFFF_FFFF); rd(A_REQ, v); chk("R10 request write ignored", v, 0);
        wr(A_PND, 32'hFFFF_FFFF); rd(A_PND, v); chk("R10 pending write ignored", v, 0);
        chk("R10 no message from writes", 32'(msg_valid), 0);
    endtask

    task automatic t_edge_merge();
        logic [31:0] v;
        irq_lines[2] = 1'b1;
        cyc(2); chk("R3 not yet valid", 32'(msg_valid), 0);
        cyc(1); chk("R3 valid third edge", 32'(msg_valid), 1);
        chk("R8 addr", msg_addr, 32'hABCD_0000);
        chk("R8 data", msg_data, 32'h3);
        irq_lines[4] = 1'b1;
        cyc(4);
        chk("R8 held without ready", 32'(msg_valid), 1);
        chk("R8 addr held", msg_addr, 32'hABCD_0000);
        drain();
        chk("R8 drained", 32'(msg_valid), 0);
        irq_lines[5] = 1'b1;
        cyc(5); chk("R6 merged no new message", 32'(msg_valid), 0);
        rd(A_REQ, v); chk("R5 request read", v, 32'h34);
        rd(A_REQ, v); chk("R5 request cleared", v, 0);
        rd(A_LVL, v); chk("R2 level", v, 32'h34);
        rd(A_PND, v); chk("R7 pending", v, 32'h34);
        rd(A_PND, v); chk("R7 pending cleared", v, 0);
    endtask

    task automatic t_fall();
        logic [31:0] v;
        irq_lines = '0;
        cyc(1); rd(A_LVL, v); chk("R2 level after one edge", v, 32'h34);
        cyc(1); rd(A_LVL, v); chk("R2 level low", v, 0);
        cyc(3); chk("R2 falling no message", 32'(msg_valid), 0);
        rd(A_REQ, v); chk("R2 falling no request", v, 0);
        rd(A_PND, v); chk("R2 falling no pending", v, 0);
    endtask

    task automatic t_masked();
        logic [31:0] v;
        wr(A_MSK, 32'h7F7);
        irq_lines[3] = 1'b1;
        cyc(5); chk("R4 masked no message", 32'(msg_valid), 0);
        rd(A_REQ, v); chk("R4 masked no request", v, 0);
        rd(A_LVL, v); chk("R2 level while masked", v, 32'h8);
        rd(A_PND, v); chk("R7 pending while masked", v, 32'h8);
        wr(A_MSK, 32'h7FF);
        cyc(5); chk("R4 unmask while high no message", 32'(msg_valid), 0);
        rd(A_REQ, v); chk("R4 unmask while high no request", v, 0);
        irq_lines[3] = 1'b0;
        cyc(3);
    endtask

    task automatic t_line9();
        logic [31:0] v;
        irq_lines[9] = 1'b1;
        cyc(5); chk("R5 line9 no message", 32'(msg_valid), 0);
        rd(A_REQ, v); chk("R5 line9 no request", v, 0);
        rd(A_PND, v); chk("R7 line9 pending", v, 32'h200);
        rd(A_LVL, v); chk("R2 line9 level", v, 32'h200);
        irq_lines[9] = 1'b0;
        cyc(3);
    endtask

    task automatic t_zero_target();
        logic [31:0] v;
        wr(A_TGT, 0);
        irq_lines[0] = 1'b1;
        cyc(5); chk("R9 zero target no message", 32'(msg_valid), 0);
        rd(A_REQ, v); chk("R9 request still recorded", v, 32'h1);
        rd(A_PND, v);
        wr(A_TGT, TGT);
        irq_lines[0] = 1'b0;
        cyc(3);
    endtask

    task automatic t_rearm();
        logic [31:0] v;
        irq_lines[10] = 1'b1;
        cyc(3); chk("R3 line10 message", 32'(msg_valid), 1);
        drain();
        rd(A_REQ, v); chk("R5 line10 request", v, 32'h400);
        irq_lines[1] = 1'b1;
        cyc(3); chk("R6 new message after clear", 32'(msg_valid), 1);
        chk("R8 data again", msg_data, 32'h3);
        drain();
        rd(A_REQ, v); chk("R6 second request", v, 32'h2);
        rd(A_PND, v);
        irq_lines = '0;
        cyc(3);
    endtask

    task automatic t_pend_only();
        logic [31:0] v;
        irq_lines[6] = 1'b1;
        cyc(3); chk("R3 line6 message", 32'(msg_valid), 1);
        drain();
        rd(A_PND, v); chk("R7 pending line6", v, 32'h40);
        rd(A_REQ, v); chk("R7 request kept by pending read", v, 32'h40);
        rd(A_LVL, v); chk("R7 level kept by pending read", v, 32'h40);
        irq_lines = '0;
        cyc(3);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(20ns * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        cyc(4);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_regs();
        t_edge_merge();
        t_fall();
        t_masked();
        t_line9();
        t_zero_target();
        t_rearm();
        t_pend_only();
        finish_run();
    end
endmodule